// File: doc/BRIEF.md
# Dual Reference Monitor Selector

This block watches two slow timing references (around 10 kHz) on behalf of a clock-synthesis loop. It decides each cycle whether the loop should follow reference A, follow reference B, or run free. It also drives a combined alarm and a free-run status flag. Each reference passes through a two-flop synchronizer followed by an edge detector. A reference counts as present while rising edges keep arriving within a programmable timeout. The select input alone chooses which reference is followed. The block never switches references by itself. If the chosen reference vanishes while the other one still runs, it only raises the alarm and reports an unstable mode.

Free run is entered automatically only when both references are gone. It is also entered whenever reset or the force input is high. After every change of select, and on every exit from automatic free run, a qualification window opens. During that window the loop's loss-of-lock flag is kept out of the alarm. An active-low output-enable input is passed through, registered, to the clock output drivers.

Top module: `refsel_supervisor`

## Requirements
- R1: With the selected reference present, `mode_o` is 2'b01 (follow A) when `sel_b_i` is 0 and 2'b10 (follow B) when `sel_b_i` is 1.
- R2: If the selected reference is absent and the other is present, `mode_o` is 2'b11 (unstable), `alarm_o` is 1 and `free_run_o` is 0; the mode never moves to the other reference.
- R3: Loss of the unselected reference leaves `mode_o` on the selected reference and, with no loss of lock, `alarm_o` low.
- R4: With both references absent and no force, `mode_o` is 2'b00, `free_run_o` is 1 and `alarm_o` is 1.
- R5: One clock after `rst_i` or `force_free_i` is sampled high, `mode_o` is 2'b00, `free_run_o` is 1 and `alarm_o` is 0, whatever the references do.
- R6: While the selected reference is present, outside force and outside the qualification window, `alarm_o` follows `lock_lost_i` one clock later. The alarm is therefore the OR of the loss-of-reference and loss-of-lock conditions.
- R7: A reference input high for a single clock is detected. If it is first sampled high at edge k, the reference is present from edge k+2, `mode_o` reflects it from edge k+3, and it stays present for LOSS_CYCLES clocks after the last detected edge.
- R8: A change of `sel_b_i`, or leaving automatic free run, blanks `lock_lost_i` from the alarm for the update at that edge and the next QUAL_CYCLES updates.
- R9: `clk_out_en_o` is the inverse of `oe_n_i`, registered by one clock, and is 0 while in reset.
- R10: `ref_valid_o` pulses for one clock for each detected rising edge of the selected reference, two clocks after the edge is sampled, and stays low while forced or in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high; also forces free run |
| ref_a_i | input | 1 | Reference A, asynchronous |
| ref_b_i | input | 1 | Reference B, asynchronous |
| sel_b_i | input | 1 | 0 follows A, 1 follows B |
| force_free_i | input | 1 | Force free run, active high |
| oe_n_i | input | 1 | Clock output enable, active low |
| lock_lost_i | input | 1 | Loss-of-lock flag from the loop |
| mode_o | output | 2 | 00 free, 01 follow A, 10 follow B, 11 unstable |
| ref_valid_o | output | 1 | Strobe per edge of the selected reference |
| alarm_o | output | 1 | Loss of reference or loss of lock |
| free_run_o | output | 1 | Free-run status |
| clk_out_en_o | output | 1 | Enable for the clock output drivers |

## Verification
The assertions assume that `sel_b_i`, `force_free_i`, `oe_n_i` and `lock_lost_i` are already synchronous to `clk`. They also assume that QUAL_CYCLES is at least one. The bench changes those inputs only on the falling edge. References are driven as one-clock pulses at periods shorter than the loss timeout, or are held low so that they time out. Each reference is thus either clearly present or clearly lost, apart from the short transitions that the reference model tracks cycle by cycle.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'b00,
        MODE_TRACK_A  = 2'b01,
        MODE_TRACK_B  = 2'b10,
        MODE_UNSTABLE = 2'b11
    } sup_mode_e;

    typedef struct packed {
        sup_mode_e mode;
        logic      alarm;
        logic      free_run;
        logic      ref_valid;
        logic      out_en;
        logic      sel_prev;
        logic      auto_fr;
    } sup_state_t;

endpackage

// File: rtl/refsel_activity_mon.sv
module refsel_activity_mon #(
    parameter int unsigned LOSS_CYCLES = 7500
) (
    input  logic clk,
    input  logic rst_i,
    input  logic ref_i,
    output logic edge_o,
    output logic alive_o
);
    localparam int unsigned CW = $clog2(LOSS_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYCLES - 1);

    // sync[0], sync[1]: synchronizer; sync[2]: previous value for edge detect
    typedef struct packed {
        logic [2:0]    sync;
        logic [CW-1:0] cnt;
        logic          alive;
    } mon_state_t;

    mon_state_t st_d, st_q;

    assign edge_o  = st_q.sync[1] & ~st_q.sync[2];
    assign alive_o = st_q.alive;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], ref_i};
        if (edge_o) begin
            st_d.cnt   = '0;
            st_d.alive = 1'b1;
        end else if (st_q.cnt == LIMIT) begin
            st_d.alive = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R7: a detected edge makes the reference present on the next update
    assert_edge_marks_present_R7: assert property (@(posedge clk) disable iff (rst_i)
        edge_o |=> alive_o);

endmodule

// File: rtl/refsel_qual_timer.sv
module refsel_qual_timer #(
    parameter int unsigned QUAL_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_i,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned QW = $clog2(QUAL_CYCLES + 1);
    localparam logic [QW-1:0] QLEN = QW'(QUAL_CYCLES);

    typedef struct packed {
        logic [QW-1:0] cnt;
    } qual_state_t;

    qual_state_t st_d, st_q;

    assign busy_o = (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cnt = QLEN;
        end else if (busy_o) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R8: a start opens the blanking window on the next cycle
    assert_start_opens_window_R8: assert property (@(posedge clk) disable iff (rst_i)
        start_i |=> busy_o);

endmodule

// File: rtl/refsel_supervisor.sv
module refsel_supervisor
    import refsel_pkg::*;
#(
    parameter int unsigned LOSS_CYCLES = 7500,
    parameter int unsigned QUAL_CYCLES = 25_000_000
) (
    input  logic       clk,
    input  logic       rst_i,
    input  logic       ref_a_i,
    input  logic       ref_b_i,
    input  logic       sel_b_i,
    input  logic       force_free_i,
    input  logic       oe_n_i,
    input  logic       lock_lost_i,
    output logic [1:0] mode_o,
    output logic       ref_valid_o,
    output logic       alarm_o,
    output logic       free_run_o,
    output logic       clk_out_en_o
);
    localparam int unsigned NREF = 2;

    logic [NREF-1:0] refs_w;
    logic [NREF-1:0] edge_w;
    logic [NREF-1:0] alive_w;
    logic            both_lost;
    logic            sel_alive;
    logic            qual_start;
    logic            qual_busy;
    logic            lol_blank;

    sup_state_t st_d, st_q;

    assign refs_w = {ref_b_i, ref_a_i};

    for (genvar g = 0; g < NREF; g++) begin : g_mon
        refsel_activity_mon #(
            .LOSS_CYCLES(LOSS_CYCLES)
        ) u_mon (
            .clk    (clk),
            .rst_i  (rst_i),
            .ref_i  (refs_w[g]),
            .edge_o (edge_w[g]),
            .alive_o(alive_w[g])
        );
    end

    refsel_qual_timer #(
        .QUAL_CYCLES(QUAL_CYCLES)
    ) u_qual (
        .clk    (clk),
        .rst_i  (rst_i),
        .start_i(qual_start),
        .busy_o (qual_busy)
    );

    always_comb begin
        both_lost  = ~|alive_w;
        sel_alive  = alive_w[sel_b_i];
        qual_start = ~rst_i & ((sel_b_i != st_q.sel_prev)
                   | (st_q.auto_fr & ~both_lost & ~force_free_i));
        lol_blank  = qual_busy | qual_start;

        st_d           = st_q;
        st_d.sel_prev  = sel_b_i;
        st_d.out_en    = ~oe_n_i;
        st_d.auto_fr   = both_lost & ~force_free_i;
        st_d.ref_valid = ~force_free_i & edge_w[sel_b_i];

        if (force_free_i) begin
            st_d.mode     = MODE_FREE;
            st_d.free_run = 1'b1;
            st_d.alarm    = 1'b0;
        end else if (both_lost) begin
            st_d.mode     = MODE_FREE;
            st_d.free_run = 1'b1;
            st_d.alarm    = 1'b1;
        end else if (!sel_alive) begin
            st_d.mode     = MODE_UNSTABLE;
            st_d.free_run = 1'b0;
            st_d.alarm    = 1'b1;
        end else begin
            st_d.mode     = sel_b_i ? MODE_TRACK_B : MODE_TRACK_A;
            st_d.free_run = 1'b0;
            st_d.alarm    = lock_lost_i & ~lol_blank;
        end

        if (rst_i) begin
            st_d.mode      = MODE_FREE;
            st_d.free_run  = 1'b1;
            st_d.alarm     = 1'b0;
            st_d.ref_valid = 1'b0;
            st_d.out_en    = 1'b0;
            st_d.sel_prev  = sel_b_i;
            st_d.auto_fr   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_o       = st_q.mode;
    assign ref_valid_o  = st_q.ref_valid;
    assign alarm_o      = st_q.alarm;
    assign free_run_o   = st_q.free_run;
    assign clk_out_en_o = st_q.out_en;

    // R2: chosen reference gone, other present -> unstable with alarm, no switch
    assert_unstable_alarm_R2: assert property (@(posedge clk) disable iff (rst_i)
        (!force_free_i && sel_b_i && alive_w[0] && !alive_w[1])
        |=> (mode_o == MODE_UNSTABLE && alarm_o && !free_run_o));

    // R3: losing the other reference keeps tracking A quietly
    assert_unselected_loss_R3: assert property (@(posedge clk) disable iff (rst_i)
        (!force_free_i && !sel_b_i && alive_w[0] && !alive_w[1] && !lock_lost_i)
        |=> (mode_o == MODE_TRACK_A && !alarm_o));

    // R4: both lost -> automatic free run with alarm
    assert_both_lost_R4: assert property (@(posedge clk) disable iff (rst_i)
        (!force_free_i && !alive_w[0] && !alive_w[1])
        |=> (mode_o == MODE_FREE && free_run_o && alarm_o));

    // R5: force wins over everything
    assert_force_free_R5: assert property (@(posedge clk) disable iff (rst_i)
        force_free_i |=> (mode_o == MODE_FREE && free_run_o && !alarm_o));

    // R6: loss of lock reaches the alarm outside the window
    assert_lol_alarm_R6: assert property (@(posedge clk) disable iff (rst_i)
        (!force_free_i && alive_w[sel_b_i] && lock_lost_i && !qual_busy && !qual_start)
        |=> alarm_o);

    // R9: output enable is the registered inverse of oe_n_i
    assert_out_enable_R9: assert property (@(posedge clk) disable iff (rst_i)
        1'b1 |=> (clk_out_en_o == !$past(oe_n_i)));

    // R10: no reference strobe while forced
    assert_no_strobe_forced_R10: assert property (@(posedge clk) disable iff (rst_i)
        force_free_i |=> !ref_valid_o);

endmodule

// File: tb/tb_refsel_supervisor.sv
module tb_refsel_supervisor;
    localparam int LOSS = 20;
    localparam int QUAL = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_a = 1'b0, ref_b = 1'b0, sel = 1'b0, frc = 1'b0, oe_n = 1'b0, lol = 1'b0;
    logic [1:0] mode;
    logic valid, alarm, fr, en;

    int checks = 0, fails = 0;
    bit done = 0;
    string cur_req = "R5";

    // stimulus generators
    bit en_a = 0, en_b = 0;
    int per_a = 10, per_b = 13, ctr_a = 0, ctr_b = 0;

    // reference model state
    int cyc = 0, last_a = -100000, last_b = -100000;
    int ha[3], hb[3];
    int m_mode = 0, m_qual = 0;
    bit m_alarm = 0, m_fr = 1, m_valid = 0, m_en = 0, m_selp = 0, m_auto = 0;

    always #10 clk = ~clk;   // 50 MHz

    refsel_supervisor #(.LOSS_CYCLES(LOSS), .QUAL_CYCLES(QUAL)) dut (
        .clk(clk), .rst_i(rst), .ref_a_i(ref_a), .ref_b_i(ref_b), .sel_b_i(sel),
        .force_free_i(frc), .oe_n_i(oe_n), .lock_lost_i(lol),
        .mode_o(mode), .ref_valid_o(valid), .alarm_o(alarm),
        .free_run_o(fr), .clk_out_en_o(en));

    // behavioural model, updated on every rising edge from the driven inputs
    always @(posedge clk) begin
        bit aa, ab, ea, eb, both, sa, start;
        cyc++;
        if (rst) begin
            m_mode = 0; m_fr = 1; m_alarm = 0; m_valid = 0; m_en = 0;
            m_selp = sel; m_auto = 0; m_qual = 0;
            last_a = -100000; last_b = -100000;
            ha = '{0, 0, 0}; hb = '{0, 0, 0};
        end else begin
            aa = (cyc - 1 - last_a) < LOSS;
            ab = (cyc - 1 - last_b) < LOSS;
            ea = ha[1] != 0 && ha[2] == 0;
            eb = hb[1] != 0 && hb[2] == 0;
            both = !aa && !ab;
            sa = sel ? ab : aa;
            start = (sel != m_selp) || (m_auto && !both && !frc);
            m_valid = !frc && (sel ? eb : ea);
            m_en = !oe_n;
            if (frc) begin m_mode = 0; m_fr = 1; m_alarm = 0; end
            else if (both) begin m_mode = 0; m_fr = 1; m_alarm = 1; end
            else if (!sa) begin m_mode = 3; m_fr = 0; m_alarm = 1; end
            else begin
                m_mode = sel ? 2 : 1; m_fr = 0;
                m_alarm = lol && !(start || m_qual > 0);
            end
            m_selp = sel;
            m_auto = both && !frc;
            m_qual = start ? QUAL : (m_qual > 0 ? m_qual - 1 : 0);
            if (ea) last_a = cyc;
            if (eb) last_b = cyc;
            ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = int'(ref_a);
            hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = int'(ref_b);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic compare();
        chk(int'(mode) == m_mode, {cur_req, " mode"}, int'(mode), m_mode);
        chk(alarm == m_alarm, {cur_req, " alarm"}, int'(alarm), int'(m_alarm));
        chk(fr == m_fr, {cur_req, " free_run"}, int'(fr), int'(m_fr));
        chk(valid == m_valid, "R10 ref_valid", int'(valid), int'(m_valid));
        chk(en == m_en, "R9 clk_out_en", int'(en), int'(m_en));
    endtask

    task automatic gen();
        if (en_a) begin
            ctr_a++;
            if (ctr_a >= per_a) begin ctr_a = 0; ref_a = 1'b1; end else ref_a = 1'b0;
        end
        if (en_b) begin
            ctr_b++;
            if (ctr_b >= per_b) begin ctr_b = 0; ref_b = 1'b1; end else ref_b = 1'b0;
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            gen();
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        // R5: reset state
        step(5);
        chk(mode == 2'b00 && fr && !alarm && !en, "R5 reset state", int'(mode), 0);
        rst = 1'b0; en_a = 1; en_b = 1;

        // R1: follow A, then B
        cur_req = "R1";
        step(60);
        chk(mode == 2'b01 && !alarm, "R1 follow A", int'(mode), 1);
        // R8: select change with loss of lock -> blanked first
        cur_req = "R8";
        sel = 1'b1; lol = 1'b1;
        step(4);
        chk(!alarm, "R8 alarm blanked", int'(alarm), 0);
        chk(mode == 2'b10, "R1 follow B", int'(mode), 2);
        cur_req = "R6";
        step(25);
        chk(alarm, "R6 loss of lock alarm", int'(alarm), 1);
        lol = 1'b0;

        // R2: selected B lost, A still present
        cur_req = "R2";
        en_b = 0; ref_b = 1'b0;
        step(50);
        chk(mode == 2'b11 && alarm && !fr, "R2 unstable", int'(mode), 3);

        // R3: B back, A lost
        cur_req = "R3";
        en_b = 1; en_a = 0; ref_a = 1'b0;
        step(50);
        chk(mode == 2'b10 && !alarm, "R3 unselected loss", int'(mode), 2);

        // R4: both lost
        cur_req = "R4";
        en_b = 0; ref_b = 1'b0;
        step(50);
        chk(mode == 2'b00 && fr && alarm, "R4 auto free run", int'(mode), 0);

        // R8: leave auto free run onto A with loss of lock
        cur_req = "R8";
        sel = 1'b0; en_a = 1; lol = 1'b1;
        step(45);
        chk(mode == 2'b01 && alarm, "R8 window ended, R6 alarm", int'(alarm), 1);
        lol = 1'b0;

        // R7: single one-clock pulse after loss
        cur_req = "R7";
        en_a = 0; ref_a = 1'b0;
        step(40);
        chk(mode == 2'b00, "R7 lost before pulse", int'(mode), 0);
        ref_a = 1'b1;
        step(1);
        ref_a = 1'b0;
        step(4);
        chk(mode == 2'b01, "R7 narrow pulse detected", int'(mode), 1);

        // R5: force free run
        cur_req = "R5";
        en_a = 1; en_b = 1;
        step(30);
        frc = 1'b1;
        step(3);
        chk(mode == 2'b00 && fr && !alarm && !valid, "R5 forced", int'(mode), 0);
        step(20);
        frc = 1'b0;
        cur_req = "R1";
        step(20);

        // R9: output enable
        oe_n = 1'b1;
        step(2);
        chk(!en, "R9 disabled", int'(en), 0);
        oe_n = 1'b0;
        step(2);
        chk(en, "R9 enabled", int'(en), 1);

        // R5: reset again while references run
        cur_req = "R5";
        rst = 1'b1;
        step(3);
        chk(mode == 2'b00 && fr && !alarm && !en, "R5 reset again", int'(mode), 0);

        done = 1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end
endmodule